// File: doc/BRIEF.md
# I2C Target with 32-bit Register Index and 32-bit Data

This block is an I2C target that sits in front of a register space. The register space is addressed by a 32-bit index and each register holds 32 bits. Both lines are sampled in the system clock domain. The block finds START, repeated START and STOP conditions and compares the 7-bit device address. Each transaction opens with a write-direction address and four index bytes. After that the master either sends four data bytes, or issues a repeated START and a read-direction address and then clocks four data bytes out of the target.

The target pulls SDA low through an output enable. It never drives the line high. On the register side there is a plain synchronous port. The index is always visible on `reg_addr`. `reg_we` is a one-cycle pulse carrying `reg_addr` and `reg_wdata`. `reg_re` is a one-cycle pulse, and the register side must present the value on `reg_rdata` in the clock cycle that follows it.

Top module: `i2c_reg32_target`

## Requirements
- R1: After a START, a byte whose upper seven bits equal `DEV_ADDR` with bit 0 = 0 (write) is acknowledged. Each of the four index bytes that follow is also acknowledged, by holding SDA low through the ninth SCL pulse.
- R2: A START followed by an address byte whose upper seven bits differ from `DEV_ADDR` is not acknowledged. No later byte is acknowledged and no register strobe fires until a new START or STOP.
- R3: After the four index bytes, four data bytes are each acknowledged. One `reg_we` pulse then carries `reg_addr` equal to the index and `reg_wdata` equal to the data. In both, the first byte on the wire is bits 31:24.
- R4: A write cut short by STOP or by a new START before its fourth data byte is acknowledged produces no `reg_we`. After a STOP the target releases SDA and waits for a START.
- R5: A repeated START followed by a matching address with bit 0 = 1 is acknowledged, and `reg_re` pulses exactly once with `reg_addr` equal to the index. The target then returns the value presented on `reg_rdata` in the cycle after `reg_re`, as four bytes with bits 31:24 first.
- R6: All four read bytes come from the value captured in the cycle after `reg_re`. Later changes on `reg_rdata` have no effect on them.
- R7: After the master does not acknowledge a read byte, the target keeps SDA released for any further SCL pulses until the next START or STOP.
- R8: A read-direction address that does not follow a complete four-byte index in the same transaction (for example, straight after a STOP) is not acknowledged and gives no `reg_re`.
- R9: `sda_oe` changes only while SCL is low.
- R10: During and right after reset, `sda_oe`, `reg_we` and `reg_re` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 32 | Register index received from the master |
| reg_wdata | output | 32 | Write data received from the master |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Read data, valid in the cycle after `reg_re` |

## Verification
The assertions assume a master that keeps to the I2C bus rules:
- SDA moves only while SCL is low, except for START and STOP.
- Each SCL level is held for several system clocks, which lets the synchronized edges settle before the next bus event.
- The master never issues START or STOP while the target is pulling SDA low.

The bench builds every transfer from quarter-bit waits of five clock cycles. It changes its own SDA level only in the low half of SCL. The bus level it samples is the AND of its own level and the target's release.

// File: rtl/i2c32_pkg.sv
package i2c32_pkg;

  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int BIDX_W     = $clog2(WORD_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_IDX,
    ST_WDAT,
    ST_RDAT,
    ST_IGNORE
  } bus_state_t;

  // address byte carries the 7-bit device address in bits 7:1
  function automatic logic addr_hits(input logic [BYTE_W-1:0] b,
                                     input logic [6:0] dev);
    return b[BYTE_W-1:1] == dev;
  endfunction

  // most significant byte arrives first: new byte enters at the bottom
  function automatic logic [WORD_W-1:0] push_byte(input logic [WORD_W-1:0] w,
                                                  input logic [BYTE_W-1:0] b);
    return {w[WORD_W-BYTE_W-1:0], b};
  endfunction

endpackage

// File: rtl/i2c32_line_sync.sv
module i2c32_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] last;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe    <= '1;
        last[g] <= 1'b1;
      end else begin
        pipe    <= {pipe[STAGES-2:0], raw[g]};
        last[g] <= pipe[STAGES-1];
      end
    end
    assign synced[g] = pipe[STAGES-1];
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  =  scl_s & ~last[0];
  assign scl_fall  = ~scl_s &  last[0];
  assign start_det =  scl_s &  last[0] &  last[1] & ~sda_s;
  assign stop_det  =  scl_s &  last[0] & ~last[1] &  sda_s;

endmodule

// File: rtl/i2c32_rx_byte.sv
module i2c32_rx_byte
  import i2c32_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] byte_now
);

  logic [BYTE_W-2:0] sh;

  // byte_now already includes the bit being sampled this cycle
  assign byte_now = {sh, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (clr)      sh <= '0;
    else if (shift_en) sh <= byte_now[BYTE_W-2:0];
  end

endmodule

// File: rtl/i2c32_tx_word.sv
module i2c32_tx_word
  import i2c32_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              shift_en,
  output logic              bit_out
);

  logic [WORD_W-1:0] word_q;

  assign bit_out = word_q[WORD_W-1];

  // ones fill in from the bottom so an over-read leaves SDA released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '1;
    else if (load)     word_q <= load_val;
    else if (shift_en) word_q <= {word_q[WORD_W-2:0], 1'b1};
  end

endmodule

// File: rtl/i2c_reg32_target.sv
module i2c_reg32_target
  import i2c32_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h5A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [WORD_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [WORD_W-1:0] reg_rdata
);

  localparam int            BITCNT_W = $clog2(BYTE_W);
  localparam logic [BITCNT_W-1:0] LAST_BIT  = BITCNT_W'(BYTE_W - 1);
  localparam logic [BIDX_W-1:0]   LAST_BYTE = BIDX_W'(WORD_BYTES - 1);

  // named bus events
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c32_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_state_t          st, pend_st;
  logic [BITCNT_W-1:0] bitcnt;
  logic [BIDX_W-1:0]   bidx;
  logic go_ack, slot_ack, pend_ack, commit_pend, idx_valid, rd_load;
  logic sda_oe_q;
  logic [WORD_W-1:0] idx_q, wbuf_q;

  logic              bus_cond, rx_active, rx_shift, tx_shift, tx_bit, byte_done;
  logic [BYTE_W-1:0] byte_now;
  bus_state_t        after_slot;

  assign bus_cond  = start_det | stop_det;
  assign rx_active = (st == ST_ADDR) || (st == ST_IDX) || (st == ST_WDAT);
  assign rx_shift  = scl_rise && !bus_cond && rx_active && !slot_ack;
  assign tx_shift  = scl_rise && !bus_cond && (st == ST_RDAT) && !slot_ack;
  assign byte_done = scl_rise && !bus_cond && !slot_ack &&
                     (rx_active || st == ST_RDAT) && (bitcnt == LAST_BIT);
  assign after_slot = (st == ST_RDAT) ? ST_RDAT : pend_st;

  i2c32_rx_byte u_rx (
    .clk(clk), .rst_n(rst_n), .clr(start_det), .shift_en(rx_shift),
    .bit_in(sda_s), .byte_now(byte_now)
  );

  i2c32_tx_word u_tx (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .load_val(reg_rdata),
    .shift_en(tx_shift), .bit_out(tx_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      pend_st     <= ST_IDLE;
      bitcnt      <= '0;
      bidx        <= '0;
      go_ack      <= 1'b0;
      slot_ack    <= 1'b0;
      pend_ack    <= 1'b0;
      commit_pend <= 1'b0;
      idx_valid   <= 1'b0;
      rd_load     <= 1'b0;
      sda_oe_q    <= 1'b0;
      idx_q       <= '0;
      wbuf_q      <= '0;
      reg_we      <= 1'b0;
      reg_re      <= 1'b0;
    end else begin
      reg_we  <= 1'b0;
      reg_re  <= 1'b0;
      rd_load <= reg_re;
      if (stop_det) begin
        st          <= ST_IDLE;
        idx_valid   <= 1'b0;
        go_ack      <= 1'b0;
        slot_ack    <= 1'b0;
        commit_pend <= 1'b0;
        sda_oe_q    <= 1'b0;
      end else if (start_det) begin
        st          <= ST_ADDR;
        bitcnt      <= '0;
        bidx        <= '0;
        go_ack      <= 1'b0;
        slot_ack    <= 1'b0;
        commit_pend <= 1'b0;
        sda_oe_q    <= 1'b0;
      end else if (st == ST_IDLE || st == ST_IGNORE) begin
        sda_oe_q <= 1'b0;
      end else if (scl_rise) begin
        if (slot_ack) begin
          // master acknowledge slot of a read byte
          if (st == ST_RDAT && sda_s) begin
            st       <= ST_IGNORE;
            slot_ack <= 1'b0;
          end
        end else begin
          bitcnt <= bitcnt + 1'b1;
          if (byte_done) begin
            go_ack <= 1'b1;
            unique case (st)
              ST_ADDR: begin
                pend_ack <= 1'b0;
                if (addr_hits(byte_now, DEV_ADDR)) begin
                  if (!byte_now[0]) begin
                    pend_ack  <= 1'b1;
                    pend_st   <= ST_IDX;
                    idx_valid <= 1'b0;
                    bidx      <= '0;
                  end else if (idx_valid) begin
                    pend_ack <= 1'b1;
                    pend_st  <= ST_RDAT;
                    reg_re   <= 1'b1;
                  end
                end
              end
              ST_IDX: begin
                idx_q    <= push_byte(idx_q, byte_now);
                pend_ack <= 1'b1;
                bidx     <= bidx + 1'b1;
                if (bidx == LAST_BYTE) begin
                  pend_st   <= ST_WDAT;
                  idx_valid <= 1'b1;
                end else begin
                  pend_st <= ST_IDX;
                end
              end
              ST_WDAT: begin
                wbuf_q   <= push_byte(wbuf_q, byte_now);
                pend_ack <= 1'b1;
                bidx     <= bidx + 1'b1;
                if (bidx == LAST_BYTE) begin
                  commit_pend <= 1'b1;
                  pend_st     <= ST_IGNORE;
                end else begin
                  pend_st <= ST_WDAT;
                end
              end
              default: ; // read byte: master answers in the slot
            endcase
          end
        end
      end else if (scl_fall) begin
        if (go_ack) begin
          go_ack <= 1'b0;
          if (st == ST_RDAT) begin
            slot_ack <= 1'b1;
            sda_oe_q <= 1'b0;
          end else if (pend_ack) begin
            slot_ack <= 1'b1;
            sda_oe_q <= 1'b1;
          end else begin
            st       <= ST_IGNORE;
            sda_oe_q <= 1'b0;
          end
        end else if (slot_ack) begin
          slot_ack <= 1'b0;
          bitcnt   <= '0;
          st       <= after_slot;
          if (commit_pend) begin
            reg_we      <= 1'b1;
            commit_pend <= 1'b0;
          end
          sda_oe_q <= (after_slot == ST_RDAT) ? ~tx_bit : 1'b0;
        end else if (st == ST_RDAT) begin
          sda_oe_q <= ~tx_bit;
        end
      end
    end
  end

  assign sda_oe    = sda_oe_q;
  assign reg_addr  = idx_q;
  assign reg_wdata = wbuf_q;

  // R3: the write strobe is a single cycle
  p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R3: a write is only committed once a full index has arrived
  p_we_has_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> idx_valid);

  // R5: the read strobe is a single cycle
  p_re_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  // R4: a STOP leaves the target idle with SDA released
  p_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE) && !sda_oe);

  // R7: the ignoring state never pulls SDA
  p_ignore_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |=> !sda_oe);

  // R9: the output enable only moves while synchronized SCL is low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

endmodule

// File: tb/test_i2c_reg32_target.sv
module test_i2c_reg32_target;

  localparam int         Q    = 5;
  localparam logic [6:0] DEV  = 7'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [31:0] reg_addr, reg_wdata, reg_rdata;
  logic        reg_we, reg_re;
  logic        sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_reg32_target #(.DEV_ADDR(DEV)) i_i2c_reg32_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  int n_vec = 0;
  int n_bad = 0;
  int we_cnt = 0;
  int re_cnt = 0;
  int r9_viol = 0;
  logic [31:0] we_addr, we_data, re_addr;
  logic prev_oe = 1'b0;
  logic oe_seen = 1'b0;
  bit   finished = 1'b0;

  function automatic logic [31:0] model_val(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  // register side: value valid the cycle after the strobe, garbage otherwise
  always_ff @(posedge clk) begin
    if (reg_re) begin
      reg_rdata <= model_val(reg_addr);
      re_cnt    <= re_cnt + 1;
      re_addr   <= reg_addr;
    end else begin
      reg_rdata <= 32'hDEAD_BEEF;
    end
    if (reg_we) begin
      we_cnt  <= we_cnt + 1;
      we_addr <= reg_addr;
      we_data <= reg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) r9_viol++;
    prev_oe = sda_oe;
    if (sda_oe) oe_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(2);
    sda_m = 1'b0; wq(2);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(2);
    sda_m = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1);
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq(1);
    end
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    acked = ~sda_bus; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1);
      scl_m = 1'b1; wq(1);
      b[i] = sda_bus; wq(1);
      scl_m = 1'b0; wq(1);
    end
    sda_m = ~master_ack; wq(1);
    scl_m = 1'b1; wq(2);
    scl_m = 1'b0; wq(1);
    sda_m = 1'b1;
  endtask

  task automatic send_index(input logic [31:0] idx, input string req);
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    chk(a, req, {31'd0, a}, 32'd1);
    for (int k = 3; k >= 0; k--) begin
      send_byte(idx[8*k +: 8], a);
      chk(a, req, {31'd0, a}, 32'd1);
    end
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R10 sda_oe", {31'd0, sda_oe}, 32'd0);
    chk(!reg_we && !reg_re, "R10 strobes", {30'd0, reg_we, reg_re}, 32'd0);
  endtask

  task automatic t_write(input logic [31:0] idx, input logic [31:0] dat);
    logic a;
    int w0 = we_cnt;
    send_index(idx, "R1 address/index ack");
    for (int k = 3; k >= 0; k--) begin
      send_byte(dat[8*k +: 8], a);
      chk(a, "R3 data ack", {31'd0, a}, 32'd1);
    end
    bus_stop();
    chk(we_cnt == w0 + 1, "R3 one write strobe", we_cnt, w0 + 1);
    chk(we_addr == idx, "R3 write index", we_addr, idx);
    chk(we_data == dat, "R3 write data", we_data, dat);
  endtask

  task automatic t_bad_addr();
    logic a;
    int w0 = we_cnt, r0 = re_cnt;
    bus_start();
    send_byte({7'h13, 1'b0}, a);
    chk(!a, "R2 foreign address nack", {31'd0, a}, 32'd0);
    oe_seen = 1'b0;
    for (int k = 0; k < 8; k++) send_byte(8'h00, a);
    chk(!oe_seen, "R2 stays released", {31'd0, oe_seen}, 32'd0);
    bus_stop();
    chk(we_cnt == w0 && re_cnt == r0, "R2 no strobes", we_cnt + re_cnt, w0 + r0);
  endtask

  task automatic t_abort_stop();
    logic a;
    int w0 = we_cnt;
    send_index(32'hCAFE_0001, "R1 index ack (abort)");
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    bus_stop();
    wq(4);
    chk(we_cnt == w0, "R4 stop discards partial write", we_cnt, w0);
    chk(!sda_oe, "R4 released after stop", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_abort_start();
    logic a;
    int w0 = we_cnt;
    send_index(32'h0BAD_F00D, "R1 index ack (restart)");
    for (int k = 0; k < 3; k++) send_byte(8'h77, a);
    chk(we_cnt == w0, "R4 start discards partial write", we_cnt, w0);
    t_write(32'h0000_0042, 32'h8899_AABB);
    chk(we_cnt == w0 + 1, "R4 only the complete write lands", we_cnt, w0 + 1);
  endtask

  task automatic t_read(input logic [31:0] idx);
    logic a;
    logic [7:0] b;
    logic [31:0] got, exp;
    int r0 = re_cnt;
    exp = model_val(idx);
    send_index(idx, "R1 index ack (read)");
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk(a, "R5 read address ack", {31'd0, a}, 32'd1);
    chk(re_cnt == r0 + 1, "R5 one read strobe", re_cnt, r0 + 1);
    chk(re_addr == idx, "R5 read index", re_addr, idx);
    for (int k = 3; k >= 0; k--) begin
      recv_byte(k != 0, b);
      got[8*k +: 8] = b;
    end
    chk(got == exp, "R5 R6 read data snapshot", got, exp);
    oe_seen = 1'b0;
    for (int k = 0; k < 2; k++) recv_byte(1'b1, b);
    chk(!oe_seen, "R7 released after master nack", {31'd0, oe_seen}, 32'd0);
    bus_stop();
    chk(re_cnt == r0 + 1, "R5 no extra read strobe", re_cnt, r0 + 1);
  endtask

  task automatic t_read_noidx();
    logic a;
    int r0 = re_cnt;
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk(!a, "R8 read without index nack", {31'd0, a}, 32'd0);
    bus_stop();
    chk(re_cnt == r0, "R8 no read strobe", re_cnt, r0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write(32'h1234_5678, 32'hA1B2_C3D4);
    t_write(32'hFF00_00FF, 32'h0000_0001);
    t_bad_addr();
    t_abort_stop();
    t_abort_start();
    t_read(32'h1234_5678);
    t_read(32'h8000_0003);
    t_read_noidx();
    chk(r9_viol == 0, "R9 oe moves only with SCL low", r9_viol, 32'd0);
    summary();
  end

endmodule